// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block sits between the product-term AND array and the macrocells of a small programmable-logic block. It forms one logic function for each of eight macrocells. Every macrocell owns a home cluster of five product terms. Four of them are basic terms. The fifth is a spare term that either joins the cluster or feeds the output XOR of the home macrocell. The home macrocell's mode sets how many basic terms take part. A synchronous home uses all four. An asynchronous home uses only the first two, and the other two are forced to 0.

A two-bit steer field sends each cluster's OR result to its home macrocell or to the macrocell 1, 2 or 3 positions above it, wrapping modulo 8. A macrocell ORs together every cluster steered to it. Its output is that sum XORed with the home cluster's spare term, or with a programmable polarity constant when the spare term is used as an extension. The configuration is static and arrives on a flat bus. The outputs are registered once.

Top module: `pta_alloc`

## Requirements
- R1: While rst_n is low, mc_o reads all zeros whatever the inputs are.
- R2: Cluster c occupies cfg_i[5c+4:5c] with bit 0 = sync, bits 2:1 = steer, bit 3 = extend, bit 4 = polarity. Its terms are pt_i[5c+4:5c], and bit 4 is the spare term. When sync is 1, any of the basic terms 0 to 3 at 1 makes the cluster's sum 1.
- R3: When sync is 0, basic terms 2 and 3 of that cluster have no effect on any output. Only terms 0 and 1, plus the spare term when extend is 1, can set the sum.
- R4: The number of active basic terms follows the cluster's own sync bit, even when the cluster is steered to a macrocell whose own cluster has the other mode.
- R5: A cluster with steer value s contributes to macrocell (c + s) mod 8 and to no other macrocell.
- R6: Each macrocell's sum is the OR of all clusters steered to it. A macrocell that receives no cluster has a sum of 0, so its output equals its XOR input.
- R7: When extend is 1, the spare term joins the cluster's OR. The home macrocell's XOR second input is then the polarity bit, so the output is the sum inverted when polarity is 1.
- R8: When extend is 0, the spare term does not enter any sum. It drives the XOR second input of the cluster's home macrocell, whatever the steer value is.
- R9: mc_o changes only at a rising clock edge. It reflects the inputs that were present at that edge.
- R10: Four synchronous extended clusters steered to one macrocell let any one of 20 terms set that macrocell. When the target's own cluster is asynchronous, exactly 18 of those terms can set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 40 | Static configuration, five bits per cluster |
| pt_i | input | 40 | Product-term values, five per cluster |
| mc_o | output | 8 | Registered macrocell functions after the XOR stage |

## Verification
Two functions can land on one macrocell in the same cycle. One is the OR of clusters steered in from lower positions. The other is the XOR input taken from the macrocell's own cluster, which is either its spare term or its polarity bit. The bench provokes this with directed cases. In these cases a neighbour's cluster is steered onto a macrocell while that macrocell's own spare term or polarity is active, and also when the home cluster is steered away so that only the XOR path remains. Long runs of random configurations and term vectors create many such overlaps. Each output bit is judged against a sum-of-products model in the bench that rebuilds the sum and the XOR input from the field definitions.

// File: rtl/pta_pkg.sv
package pta_pkg;
    parameter int STEER_W = 2;

    typedef struct packed {
        logic               pol;
        logic               ext;
        logic [STEER_W-1:0] steer;
        logic               sync;
    } cl_cfg_t;

    localparam int CFG_W = $bits(cl_cfg_t);
endpackage

// File: rtl/pta_cluster_gate.sv
module pta_cluster_gate
    import pta_pkg::*;
#(
    parameter int BASIC_SYNC  = 4,
    parameter int BASIC_ASYNC = 2,
    localparam int TPC        = BASIC_SYNC + 1
) (
    input  logic [TPC-1:0] terms_i,
    input  cl_cfg_t        cfg_i,
    output logic           contrib_o,
    output logic           spare_o
);
    always_comb begin
        contrib_o = 1'b0;
        for (int i = 0; i < BASIC_SYNC; i++) begin
            // terms beyond the async count are held at 0 unless the home is synchronous
            if ((i < BASIC_ASYNC) || cfg_i.sync) begin
                contrib_o = contrib_o | terms_i[i];
            end
        end
        if (cfg_i.ext) begin
            contrib_o = contrib_o | terms_i[BASIC_SYNC];
        end
        spare_o = cfg_i.ext ? cfg_i.pol : terms_i[BASIC_SYNC];
    end
endmodule

// File: rtl/pta_steer_net.sv
module pta_steer_net #(
    parameter int NUM_MC  = 8,
    parameter int STEER_W = 2
) (
    input  logic [NUM_MC-1:0]         contrib_i,
    input  logic [NUM_MC*STEER_W-1:0] steer_i,
    output logic [NUM_MC-1:0]         sum_o
);
    always_comb begin
        sum_o = '0;
        for (int m = 0; m < NUM_MC; m++) begin
            for (int c = 0; c < NUM_MC; c++) begin
                if (((c + int'(steer_i[c*STEER_W +: STEER_W])) % NUM_MC) == m) begin
                    sum_o[m] = sum_o[m] | contrib_i[c];
                end
            end
        end
    end
endmodule

// File: rtl/pta_xor_stage.sv
module pta_xor_stage #(
    parameter int NUM_MC = 8
) (
    input  logic [NUM_MC-1:0] sum_i,
    input  logic [NUM_MC-1:0] xin_i,
    output logic [NUM_MC-1:0] out_o
);
    for (genvar m = 0; m < NUM_MC; m++) begin : g_bit
        assign out_o[m] = sum_i[m] ^ xin_i[m];
    end
endmodule

// File: rtl/pta_alloc.sv
module pta_alloc
    import pta_pkg::*;
#(
    parameter int NUM_MC      = 8,
    parameter int BASIC_SYNC  = 4,
    parameter int BASIC_ASYNC = 2,
    localparam int TPC        = BASIC_SYNC + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_MC*CFG_W-1:0] cfg_i,
    input  logic [NUM_MC*TPC-1:0]   pt_i,
    output logic [NUM_MC-1:0]       mc_o
);
    typedef struct packed {
        logic [NUM_MC-1:0] mc;
    } state_t;

    cl_cfg_t                   cfg_arr [NUM_MC];
    logic [NUM_MC*STEER_W-1:0] steer_flat;
    logic [NUM_MC-1:0]         cl_contrib;
    logic [NUM_MC-1:0]         cl_spare;
    logic [NUM_MC-1:0]         mc_sum;
    logic [NUM_MC-1:0]         mc_xor;
    state_t                    st_d, st_q;

    for (genvar c = 0; c < NUM_MC; c++) begin : g_cl
        assign cfg_arr[c] = cl_cfg_t'(cfg_i[c*CFG_W +: CFG_W]);
        assign steer_flat[c*STEER_W +: STEER_W] = cfg_arr[c].steer;

        pta_cluster_gate #(
            .BASIC_SYNC (BASIC_SYNC),
            .BASIC_ASYNC(BASIC_ASYNC)
        ) u_gate (
            .terms_i  (pt_i[c*TPC +: TPC]),
            .cfg_i    (cfg_arr[c]),
            .contrib_o(cl_contrib[c]),
            .spare_o  (cl_spare[c])
        );
    end

    pta_steer_net #(
        .NUM_MC (NUM_MC),
        .STEER_W(STEER_W)
    ) u_steer (
        .contrib_i(cl_contrib),
        .steer_i  (steer_flat),
        .sum_o    (mc_sum)
    );

    pta_xor_stage #(
        .NUM_MC(NUM_MC)
    ) u_xor (
        .sum_i(mc_sum),
        .xin_i(cl_spare),
        .out_o(mc_xor)
    );

    always_comb begin
        st_d    = st_q;
        st_d.mc = mc_xor;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mc_o = st_q.mc;
endmodule

// File: rtl/pta_alloc_chk.sv
module pta_alloc_chk
    import pta_pkg::*;
#(
    parameter int NUM_MC      = 8,
    parameter int BASIC_SYNC  = 4,
    parameter int BASIC_ASYNC = 2,
    localparam int TPC        = BASIC_SYNC + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_MC*CFG_W-1:0] cfg_i,
    input logic [NUM_MC*TPC-1:0]   pt_i,
    input logic [NUM_MC-1:0]       mc_o,
    input logic [NUM_MC-1:0]       contrib_i,
    input logic [NUM_MC-1:0]       sum_i
);
    logic [NUM_MC-1:0] ext_vec;
    logic [NUM_MC-1:0] pol_vec;
    logic [NUM_MC-1:0] no_src;

    always_comb begin
        no_src = '1;
        for (int c = 0; c < NUM_MC; c++) begin
            ext_vec[c] = cfg_i[c*CFG_W + 3];
            pol_vec[c] = cfg_i[c*CFG_W + 4];
            no_src[(c + int'(cfg_i[c*CFG_W+1 +: STEER_W])) % NUM_MC] = 1'b0;
        end
    end

    for (genvar c = 0; c < NUM_MC; c++) begin : g_cl
        // R2: a synchronous home lets any basic term through
        a_r2_sync_any: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_i[c*CFG_W] && (|pt_i[c*TPC +: BASIC_SYNC])) |-> contrib_i[c]);
        // R3: an asynchronous cluster without its first terms or spare stays low
        a_r3_async_masked: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_i[c*CFG_W] && !ext_vec[c] && (pt_i[c*TPC +: BASIC_ASYNC] == '0))
            |-> !contrib_i[c]);
    end

    for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
        // R6: a macrocell with no cluster aimed at it has an empty sum
        a_r6_unsourced_zero: assert property (@(posedge clk) disable iff (!rst_n)
            no_src[m] |-> !sum_i[m]);
    end

    // R7: with every spare used as extension and no terms high, outputs show polarity
    a_r7_pol_only: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && (pt_i == '0) && (ext_vec == '1)) |-> (mc_o == $past(pol_vec)));

    // R8: with spares on the XOR path and no terms high, outputs are zero
    a_r8_spare_xor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && (pt_i == '0) && (ext_vec == '0)) |-> (mc_o == '0));
endmodule

bind pta_alloc pta_alloc_chk #(
    .NUM_MC     (NUM_MC),
    .BASIC_SYNC (BASIC_SYNC),
    .BASIC_ASYNC(BASIC_ASYNC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_i    (cfg_i),
    .pt_i     (pt_i),
    .mc_o     (mc_o),
    .contrib_i(cl_contrib),
    .sum_i    (mc_sum)
);

// File: tb/pta_alloc_tb.sv
module pta_alloc_tb;
    localparam int NMC = 8;
    localparam int TW  = 5;
    localparam int W   = NMC * TW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cfg_i = '0;
    logic [W-1:0] pt_i = '0;
    logic [NMC-1:0] mc_o;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pta_alloc u_dut (
        .clk  (clk),
        .rst_n(rst_n),
        .cfg_i(cfg_i),
        .pt_i (pt_i),
        .mc_o (mc_o)
    );

    function automatic logic [4:0] fld(bit sync, int steer, bit ext, bit pol);
        logic [1:0] s = steer[1:0];
        return {pol, ext, s, sync};
    endfunction

    function automatic logic [W-1:0] all_cfg(logic [4:0] f);
        logic [W-1:0] r;
        for (int c = 0; c < NMC; c++) r[c*TW +: TW] = f;
        return r;
    endfunction

    function automatic logic [NMC-1:0] model(logic [W-1:0] cfg, logic [W-1:0] pt);
        logic [NMC-1:0] s = '0;
        logic [NMC-1:0] x = '0;
        for (int c = 0; c < NMC; c++) begin
            logic [4:0] f = cfg[c*TW +: TW];
            logic [4:0] t = pt[c*TW +: TW];
            logic v = t[0] | t[1];
            if (f[0]) v = v | t[2] | t[3];
            if (f[3]) v = v | t[4];
            s[(c + int'(f[2:1])) % NMC] |= v;
            x[c] = f[3] ? f[4] : t[4];
        end
        return s ^ x;
    endfunction

    task automatic chk(string tag, logic [NMC-1:0] act, logic [NMC-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(logic [W-1:0] cfg, logic [W-1:0] pt, logic [NMC-1:0] exp, string tag);
        @(negedge clk);
        cfg_i = cfg;
        pt_i  = pt;
        @(posedge clk);
        #1;
        chk(tag, mc_o, exp);
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] cfg;
        logic [W-1:0] pt;
        void'($urandom(32'h5eed_0101));

        // R1: reset holds outputs at zero even with active inputs
        cfg_i = all_cfg(fld(1, 0, 1, 1));
        pt_i  = '1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", mc_o, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: every basic term of a synchronous cluster reaches its home
        for (int c = 0; c < NMC; c++)
            for (int i = 0; i < 4; i++)
                run(all_cfg(fld(1, 0, 1, 0)), W'(1) << (c*TW + i), NMC'(1) << c, "R2 sync term");

        // R3: asynchronous cluster ignores terms 2 and 3
        cfg = all_cfg(fld(1, 0, 1, 0));
        cfg[2*TW +: TW] = fld(0, 0, 1, 0);
        run(cfg, W'(3) << (2*TW + 2), '0, "R3 async upper terms");
        run(cfg, W'(1) << (2*TW + 1), 8'h04, "R3 async term1");
        run(cfg, W'(1) << (2*TW + 4), 8'h04, "R3 async spare");

        // R4: size set by home mode, not by the destination's mode
        cfg = all_cfg(fld(1, 0, 1, 0));
        cfg[5*TW +: TW] = fld(0, 1, 1, 0);
        run(cfg, W'(1) << (5*TW + 3), '0, "R4 async steered to sync");
        run(cfg, W'(1) << (5*TW + 0), 8'h40, "R4 async steered term0");
        cfg = all_cfg(fld(1, 0, 1, 0));
        cfg[2*TW +: TW] = fld(0, 0, 1, 0);
        cfg[1*TW +: TW] = fld(1, 1, 1, 0);
        run(cfg, W'(1) << (1*TW + 3), 8'h04, "R4 sync steered to async");

        // R5: every steer value on every cluster
        for (int c = 0; c < NMC; c++)
            for (int s = 0; s < 4; s++) begin
                cfg = all_cfg(fld(1, 0, 1, 0));
                cfg[c*TW +: TW] = fld(1, s, 1, 0);
                run(cfg, W'(1) << (c*TW), NMC'(1) << ((c + s) % NMC), "R5 steer");
            end

        // R6: macrocell 0 receives no cluster
        cfg = all_cfg(fld(1, 0, 1, 0));
        cfg[0*TW +: TW] = fld(1, 1, 1, 0);
        run(cfg, '1, 8'hFE, "R6 unsourced sum zero");
        cfg[0*TW +: TW] = fld(1, 1, 1, 1);
        run(cfg, '1, 8'hFF, "R6 unsourced shows xor input");
        run(cfg, '0, 8'h01, "R6 unsourced polarity only");

        // R7: polarity with extension
        cfg = '0;
        for (int c = 0; c < NMC; c++) cfg[c*TW +: TW] = fld(1, 0, 1, (8'hA5 >> c) & 1);
        run(cfg, '0, 8'hA5, "R7 polarity pattern");
        run(cfg, W'(1) << (3*TW + 4), 8'hAD, "R7 spare joins sum");
        run(cfg, W'(1) << (0*TW + 4), 8'hA4, "R7 inverted output");

        // R8: spare drives home XOR, collision with steered-in sum
        cfg = all_cfg(fld(1, 0, 0, 1));
        run(cfg, W'(1) << (4*TW + 4), 8'h10, "R8 spare xor");
        cfg[4*TW +: TW] = fld(1, 1, 0, 0);
        run(cfg, W'(1) << (4*TW + 4), 8'h10, "R8 spare stays home");
        run(cfg, (W'(1) << (4*TW + 4)) | (W'(1) << (4*TW)), 8'h30, "R8 spare home sum away");
        cfg[3*TW +: TW] = fld(1, 1, 0, 0);
        run(cfg, (W'(1) << (4*TW + 4)) | (W'(1) << (3*TW)), 8'h00, "R8 steered-in sum meets spare");

        // R9: output holds between edges
        run(all_cfg(fld(1, 0, 1, 0)), W'(1), 8'h01, "R9 setup");
        @(negedge clk);
        pt_i = W'(1) << TW;
        #1;
        chk("R9 no change before edge", mc_o, 8'h01);
        @(posedge clk);
        #1;
        chk("R9 change at edge", mc_o, 8'h02);

        // R10: gathering four extended clusters onto macrocell 3
        cfg = all_cfg(fld(1, 0, 1, 0));
        for (int c = 0; c < 4; c++) cfg[c*TW +: TW] = fld(1, 3 - c, 1, 0);
        for (int k = 0; k < 20; k++) run(cfg, W'(1) << k, 8'h08, "R10 twenty terms");
        cfg[3*TW +: TW] = fld(0, 0, 1, 0);
        for (int k = 0; k < 20; k++)
            run(cfg, W'(1) << k, (k == 17 || k == 18) ? 8'h00 : 8'h08, "R10 eighteen terms");

        // random mix, judged by the sum-of-products model (R2..R8)
        for (int n = 0; n < 600; n++) begin
            cfg = {$urandom, $urandom};
            pt  = {$urandom, $urandom};
            if (n % 2 == 0) pt = pt & {$urandom, $urandom} & {$urandom, $urandom};
            run(cfg, pt, model(cfg, pt), "R6 R8 random model");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule